// File: doc/BRIEF.md
# Manchester Frame Assembler

This block sits behind a slicer and clock recovery stage in a downlink receiver. It takes a stream of strobed chips, pairs consecutive chips into Manchester bits and flags any pair that is not a legal symbol. The decoded bits are gathered into a frame whose length is chosen from its very first bit. A finished frame is pushed byte by byte into the write side of a FIFO that feeds a serial transmitter.

A frame is started by a start-of-frame pulse from the preamble detector. A frame that holds a bad symbol, or that finds the FIFO full when it completes, is discarded whole, so the serial link only ever carries clean, complete frames. While a frame is being emitted, the receive side is closed. This keeps the byte store from being overwritten during the drain.

Top module: `manch_frame_asm`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `wr_en`, `frame_done` and `manch_err` are low.
- R2: Chips are paired in arrival order starting with the first chip after an accepted `sof`. A chip strobed in the same cycle as an accepted `sof` is the first chip of the new frame. A pair of high then low decodes to bit 1, and a pair of low then high decodes to bit 0.
- R3: If the first decoded bit is a valid 1, the frame holds 112 bits and is emitted as 14 bytes. Otherwise it holds 56 bits and is emitted as 7 bytes.
- R4: Bytes are emitted in arrival order. Byte 0 carries the first received bit in bit 7, and each later bit fills the next lower position.
- R5: `frame_done` is high for exactly one cycle per emitted frame, in the same cycle as the strobe of its last byte.
- R6: A pair of two equal chips gives a single-cycle `manch_err` pulse in the cycle after the second chip is sampled. A frame that contains such a pair emits no byte and no `frame_done`.
- R7: A complete frame is dropped in full if `fifo_full` is high at the second rising edge after its final chip is sampled.
- R8: No `wr_en` is issued in the cycle after an edge at which `fifo_full` was high. Stalled bytes are held and later emitted in their original order.
- R9: Chips that arrive while no frame is open, before any `sof` or after a frame ends, are ignored. Chips and `sof` that arrive while a frame is being emitted are also ignored.
- R10: An accepted `sof` in the middle of a frame discards the partial bits and starts a new frame.
- R11: A `sof` sampled at the same edge at which a completed frame is accepted for emission is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_stb | input | 1 | Chip valid strobe from clock recovery |
| chip_val | input | 1 | Sliced chip value |
| sof | input | 1 | Start-of-frame pulse from the preamble detector |
| fifo_full | input | 1 | Downstream FIFO cannot take a byte |
| wr_en | output | 1 | FIFO write strobe |
| wr_byte | output | 8 | Byte to write |
| frame_done | output | 1 | Pulse with the last byte of an emitted frame |
| manch_err | output | 1 | Pulse on an invalid chip pair |

## Verification
The sharpest collision is a start-of-frame arriving at the very edge at which a finished frame is handed to the emitter. The bench releases `sof` exactly two edges after the last chip and then keeps strobing the chips of a second frame. It judges the result by seeing that only the first frame's bytes reach the port, with a single `frame_done`. A second collision is `sof` sharing its cycle with the first chip. This is judged by the frame decoding with correct pairing instead of shifting by one chip.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_EMIT
  } mfa_state_t;
endpackage

// File: rtl/mfa_chip_pair.sv
// Pairs strobed chips into Manchester bits; flags equal-chip pairs.
module mfa_chip_pair (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable,
  input  logic chip_stb,
  input  logic chip_val,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_bad
);
  logic half_q;
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
      bit_bad <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      bit_bad <= 1'b0;
      if (restart) begin
        // a chip in the restart cycle opens the new pair
        half_q  <= chip_stb;
        first_q <= chip_val;
      end else if (enable && chip_stb) begin
        if (!half_q) begin
          half_q  <= 1'b1;
          first_q <= chip_val;
        end else begin
          half_q  <= 1'b0;
          bit_stb <= 1'b1;
          bit_val <= first_q;
          bit_bad <= (first_q == chip_val);
        end
      end
    end
  end
endmodule

// File: rtl/mfa_bit_collect.sv
// Counts bits, picks the frame length from bit 0, packs bytes MSB first.
module mfa_bit_collect #(
  parameter int LONG_BITS  = 112,
  parameter int SHORT_BITS = 56,
  parameter int BYTE_W     = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  restart,
  input  logic                                  bit_stb,
  input  logic                                  bit_val,
  input  logic                                  bit_bad,
  output logic                                  ram_we,
  output logic [$clog2(LONG_BITS/BYTE_W)-1:0]   ram_addr,
  output logic [BYTE_W-1:0]                     ram_data,
  output logic                                  done,
  output logic                                  done_bad,
  output logic [$clog2(LONG_BITS/BYTE_W):0]     done_bytes
);
  localparam int MAX_BYTES = LONG_BITS / BYTE_W;
  localparam int ADDR_W    = $clog2(MAX_BYTES);
  localparam int CNT_W     = $clog2(LONG_BITS + 1);
  localparam int SUB_W     = $clog2(BYTE_W);

  logic              armed_q;
  logic              long_q;
  logic              bad_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;

  logic [BYTE_W-1:0] next_byte;
  logic [CNT_W-1:0]  frame_bits;
  logic              take;
  logic              is_last;
  logic              byte_end;

  always_comb begin
    take      = bit_stb && armed_q && !restart;
    next_byte = {shreg_q[BYTE_W-2:0], bit_val};
    if (cnt_q == '0)
      frame_bits = (bit_val && !bit_bad) ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
    else
      frame_bits = long_q ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
    is_last  = (cnt_q == frame_bits - CNT_W'(1));
    byte_end = (cnt_q[SUB_W-1:0] == {SUB_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      long_q     <= 1'b0;
      bad_q      <= 1'b0;
      cnt_q      <= '0;
      shreg_q    <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_data   <= '0;
      done       <= 1'b0;
      done_bad   <= 1'b0;
      done_bytes <= '0;
    end else begin
      ram_we <= 1'b0;
      done   <= 1'b0;
      if (restart) begin
        armed_q <= 1'b1;
        long_q  <= 1'b0;
        bad_q   <= 1'b0;
        cnt_q   <= '0;
      end else if (take) begin
        shreg_q <= next_byte;
        bad_q   <= bad_q | bit_bad;
        if (cnt_q == '0) long_q <= bit_val && !bit_bad;
        if (byte_end) begin
          ram_we   <= 1'b1;
          ram_addr <= ADDR_W'(cnt_q >> SUB_W);
          ram_data <= next_byte;
        end
        if (is_last) begin
          armed_q    <= 1'b0;
          cnt_q      <= '0;
          done       <= 1'b1;
          done_bad   <= bad_q | bit_bad;
          done_bytes <= (ADDR_W+1)'(frame_bits >> SUB_W);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mfa_byte_ram.sv
// Simple dual-port byte store with registered read (block RAM style).
module mfa_byte_ram #(
  parameter int DEPTH = 14,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/manch_frame_asm.sv
module manch_frame_asm #(
  parameter int LONG_BITS  = 112,
  parameter int SHORT_BITS = 56,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_stb,
  input  logic              chip_val,
  input  logic              sof,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              frame_done,
  output logic              manch_err
);
  import mfa_pkg::*;

  localparam int MAX_BYTES = LONG_BITS / BYTE_W;
  localparam int ADDR_W    = $clog2(MAX_BYTES);

  mfa_state_t        state_q;
  logic [ADDR_W-1:0] rd_idx_q;
  logic [ADDR_W-1:0] last_idx_q;
  logic              primed_q;

  logic              bit_stb, bit_val, bit_bad;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [BYTE_W-1:0] ram_wdata, ram_rdata;
  logic              coll_done, coll_bad;
  logic [ADDR_W:0]   coll_bytes;

  logic accept, sof_acc, do_write, at_last;

  always_comb begin
    accept    = (state_q == ST_RECV) && coll_done && !coll_bad && !fifo_full;
    sof_acc   = sof && (state_q != ST_EMIT) && !accept;
    do_write  = (state_q == ST_EMIT) && primed_q && !fifo_full;
    at_last   = (rd_idx_q == last_idx_q);
    ram_raddr = (do_write && !at_last) ? rd_idx_q + ADDR_W'(1) : rd_idx_q;
  end

  mfa_chip_pair u_pair (
    .clk      (clk),
    .rst      (rst),
    .restart  (sof_acc),
    .enable   (state_q == ST_RECV),
    .chip_stb (chip_stb),
    .chip_val (chip_val),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .bit_bad  (bit_bad)
  );

  mfa_bit_collect #(
    .LONG_BITS  (LONG_BITS),
    .SHORT_BITS (SHORT_BITS),
    .BYTE_W     (BYTE_W)
  ) u_collect (
    .clk        (clk),
    .rst        (rst),
    .restart    (sof_acc),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .bit_bad    (bit_bad),
    .ram_we     (ram_we),
    .ram_addr   (ram_waddr),
    .ram_data   (ram_wdata),
    .done       (coll_done),
    .done_bad   (coll_bad),
    .done_bytes (coll_bytes)
  );

  mfa_byte_ram #(
    .DEPTH (MAX_BYTES),
    .WIDTH (BYTE_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign manch_err = bit_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rd_idx_q   <= '0;
      last_idx_q <= '0;
      primed_q   <= 1'b0;
      wr_en      <= 1'b0;
      wr_byte    <= '0;
      frame_done <= 1'b0;
    end else begin
      wr_en      <= do_write;
      frame_done <= do_write && at_last;
      if (do_write) wr_byte <= ram_rdata;
      unique case (state_q)
        ST_IDLE: if (sof_acc) state_q <= ST_RECV;
        ST_RECV: begin
          if (accept) begin
            state_q    <= ST_EMIT;
            rd_idx_q   <= '0;
            primed_q   <= 1'b0;
            last_idx_q <= ADDR_W'(coll_bytes - (ADDR_W+1)'(1));
          end else if (!sof_acc && coll_done) begin
            state_q <= ST_IDLE;
          end
        end
        ST_EMIT: begin
          primed_q <= 1'b1;
          if (do_write) begin
            rd_idx_q <= rd_idx_q + ADDR_W'(1);
            if (at_last) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int LONG_BITS  = 112,
  parameter int SHORT_BITS = 56,
  parameter int BYTE_W     = 8
) (
  input logic clk,
  input logic rst,
  input logic fifo_full,
  input logic wr_en,
  input logic frame_done,
  input logic manch_err
);
  localparam int LONG_LAST  = LONG_BITS / BYTE_W - 1;
  localparam int SHORT_LAST = SHORT_BITS / BYTE_W - 1;

  logic [7:0] wr_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || frame_done) wr_cnt_q <= '0;
    else if (wr_en)        wr_cnt_q <= wr_cnt_q + 8'd1;
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_en && !frame_done && !manch_err)); // R1

  AST_DONE_WITH_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> wr_en); // R5

  AST_FRAME_BYTE_COUNT: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (wr_cnt_q == 8'(LONG_LAST) || wr_cnt_q == 8'(SHORT_LAST))); // R3

  AST_NO_WRITE_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(fifo_full)); // R8

  AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    manch_err |=> !manch_err); // R6

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R5
endmodule

bind manch_frame_asm mfa_checker #(
  .LONG_BITS  (LONG_BITS),
  .SHORT_BITS (SHORT_BITS),
  .BYTE_W     (BYTE_W)
) u_mfa_checker (
  .clk        (clk),
  .rst        (rst),
  .fifo_full  (fifo_full),
  .wr_en      (wr_en),
  .frame_done (frame_done),
  .manch_err  (manch_err)
);

// File: tb/manch_frame_asm_test.sv
`timescale 1ns/1ps
module manch_frame_asm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_stb = 1'b0;
  logic       chip_val = 1'b0;
  logic       sof = 1'b0;
  logic       fifo_full = 1'b0;
  logic       wr_en;
  logic [7:0] wr_byte;
  logic       frame_done;
  logic       manch_err;

  int checks = 0;
  int failures = 0;

  logic [7:0] got [64];
  int n_got = 0;
  int n_done = 0;
  int done_at = 0;
  int n_err = 0;
  int n_full_viol = 0;

  localparam logic [111:0] SHORT_A = {56'h0A_5C_33_F0_12_9E_C7, 56'h0};
  localparam logic [111:0] SHORT_B = {56'h31_E4_07_BB_6D_58_A2, 56'h0};
  localparam logic [111:0] LONG_A  = 112'h8D_4B_17_2C_99_E1_05_A3_6F_10_BE_77_D2_48;

  always #5 clk = ~clk;

  manch_frame_asm uut (
    .clk        (clk),
    .rst        (rst),
    .chip_stb   (chip_stb),
    .chip_val   (chip_val),
    .sof        (sof),
    .fifo_full  (fifo_full),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .frame_done (frame_done),
    .manch_err  (manch_err)
  );

  // monitor, 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (!rst) begin
      if (wr_en) begin
        if (n_got < 64) got[n_got] = wr_byte;
        n_got++;
        if (fifo_full) n_full_viol++;
      end
      if (frame_done) begin
        n_done++;
        done_at = n_got;
      end
      if (manch_err) n_err++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_got = 0; n_done = 0; done_at = 0; n_err = 0; n_full_viol = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0: sof in its own cycle, 1: sof with first chip, 2: no sof
  task automatic send_frame(input logic [111:0] fr, input int nbits,
                            input int bad1, input int bad2, input int mode);
    if (mode == 0) begin
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
    end
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = fr[111-i];
      @(negedge clk);
      chip_stb = 1'b1; chip_val = b;
      if (mode == 1 && i == 0) sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
      chip_val = (i == bad1 || i == bad2) ? b : ~b;
    end
    @(negedge clk);
    chip_stb = 1'b0;
  endtask

  task automatic expect_frame(input logic [111:0] fr, input int nbytes, input string tag);
    chk(n_got == nbytes, {tag, " byte count"}, n_got, nbytes);
    for (int k = 0; k < nbytes && k < n_got; k++) begin
      logic [7:0] e;
      e = fr[111-8*k -: 8];
      chk(got[k] == e, {tag, " byte value"}, got[k], e);
    end
    chk(n_done == 1 && done_at == nbytes, {tag, " frame_done"}, done_at, nbytes);
  endtask

  task automatic t_reset();
    settle(3);
    chk(!wr_en && !frame_done && !manch_err, "R1 reset quiet",
        {wr_en, frame_done, manch_err}, 0);
    rst = 1'b0;
    @(posedge clk); #2;
    chk(!wr_en && !frame_done && !manch_err, "R1 after release",
        {wr_en, frame_done, manch_err}, 0);
  endtask

  task automatic t_short();
    clear_mon();
    send_frame(SHORT_A, 56, -1, -1, 0);
    settle(30);
    expect_frame(SHORT_A, 7, "R2 R3 R4 R5 short");
  endtask

  task automatic t_long();
    clear_mon();
    send_frame(LONG_A, 112, -1, -1, 0);
    settle(40);
    expect_frame(LONG_A, 14, "R3 R4 R5 long");
  endtask

  task automatic t_bad();
    clear_mon();
    send_frame(LONG_A, 112, 20, 77, 0);
    settle(40);
    chk(n_err == 2, "R6 error pulses", n_err, 2);
    chk(n_got == 0 && n_done == 0, "R6 bad frame dropped", n_got, 0);
  endtask

  task automatic t_idle_ignore();
    clear_mon();
    send_frame(SHORT_B, 56, 3, -1, 2);
    settle(30);
    chk(n_got == 0 && n_err == 0, "R9 chips without sof", n_got + n_err, 0);
    clear_mon();
    send_frame(SHORT_B, 56, -1, -1, 0);
    settle(30);
    expect_frame(SHORT_B, 7, "R9 following frame");
  endtask

  task automatic t_full_drop();
    clear_mon();
    @(negedge clk); fifo_full = 1'b1;
    send_frame(SHORT_A, 56, -1, -1, 0);
    settle(10);
    fifo_full = 1'b0;
    settle(30);
    chk(n_got == 0 && n_done == 0, "R7 full at completion drops", n_got, 0);
    clear_mon();
    send_frame(SHORT_B, 56, -1, -1, 0);
    settle(30);
    expect_frame(SHORT_B, 7, "R7 next frame");
  endtask

  task automatic t_backpressure();
    clear_mon();
    send_frame(LONG_A, 112, -1, -1, 0);
    settle(2);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      fifo_full = (i % 3 != 1);
    end
    @(negedge clk); fifo_full = 1'b0;
    settle(30);
    expect_frame(LONG_A, 14, "R8 stalled drain");
    chk(n_full_viol == 0, "R8 no write after full", n_full_viol, 0);
  endtask

  task automatic t_restart();
    clear_mon();
    send_frame(LONG_A, 30, -1, -1, 0);
    send_frame(SHORT_B, 56, -1, -1, 0);
    settle(30);
    expect_frame(SHORT_B, 7, "R10 restart mid-frame");
  endtask

  task automatic t_sof_with_chip();
    clear_mon();
    send_frame(SHORT_A, 56, -1, -1, 1);
    settle(30);
    expect_frame(SHORT_A, 7, "R2 sof with first chip");
  endtask

  task automatic t_sof_at_accept();
    clear_mon();
    send_frame(SHORT_A, 56, -1, -1, 0);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    send_frame(SHORT_B, 56, -1, -1, 2);
    settle(30);
    expect_frame(SHORT_A, 7, "R11 sof at accept ignored");
    chk(n_err == 0, "R9 chips during emit ignored", n_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_short();
    t_long();
    t_bad();
    t_idle_ignore();
    t_full_drop();
    t_backpressure();
    t_restart();
    t_sof_with_chip();
    t_sof_at_accept();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule